// File: doc/BRIEF.md
# Acquisition Sample Buffer with Flag-Gated Access

This block is a single-clock first-in first-out buffer that holds converter samples between the sample producer and the processor-side consumer. It is 16 bits wide and 4096 entries deep by default. It reports three occupancy flags: empty, half full and full. The same flags decide, cycle by cycle, which of the two pending requests is allowed to proceed.

The policy works as follows. A read is never serviced from an empty buffer, and a write is never stored into a full one. Below the half-full mark, a write that arrives in the same cycle as a read wins, and the read is held back. This lets a burst build up before the consumer starts to drain it. From the half-full mark upward, both sides proceed together, so the occupancy holds steady.

Writes that arrive while the buffer is full are discarded. Each discarded write is counted in a saturating counter. Read data is registered and is flagged valid one clock after the read is granted. A parameter can disable the half-full gating, so that reads and writes always proceed together whenever the buffer is neither empty nor full.

Top module: `acq_fifo`

## Requirements
- R1: After reset, empty is 1, half_full is 0, full is 0, rd_valid is 0 and drop_count is 0.
- R2: Words are read out in the order they were accepted. rd_valid is 1 in the cycle after a granted read, and rd_data then holds that word.
- R3: A read request while the buffer is empty is refused: rd_valid is 0 in the following cycle and the buffer stays empty.
- R4: full is 1 exactly when 4096 words are held. A write while full is not stored: later reads never return it.
- R5: half_full is 1 exactly when at least 2048 words are held.
- R6: When the buffer holds between 1 and 2047 words and both requests are present, only the write is granted. The occupancy grows by one and rd_valid is 0 in the next cycle.
- R7: When the buffer holds between 2048 and 4095 words and both requests are present, both are granted. The occupancy is unchanged and rd_valid is 1 in the next cycle.
- R8: When the buffer is full and both requests are present, the read is granted and the write is dropped. The occupancy falls to 4095 and full clears.
- R9: Each write dropped because the buffer is full adds one to drop_count. drop_count stops at 65535.
- R10: When the buffer is empty and both requests are present, only the write is granted. The occupancy becomes 1 and rd_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Sample write request |
| wr_data | input | 16 | Sample to store |
| rd_req | input | 1 | Read request from the consumer |
| rd_data | output | 16 | Word read out, valid when rd_valid is 1 |
| rd_valid | output | 1 | Read data valid, one clock after a granted read |
| empty | output | 1 | No words held |
| half_full | output | 1 | At least half the depth held |
| full | output | 1 | All entries held |
| drop_count | output | 16 | Saturating count of writes dropped while full |

## Verification
The hardest state to reach is a saturated drop counter on a full buffer. Getting there needs the whole depth filled and then more than 65535 rejected writes, with the stored contents left intact throughout. The stimulus first fills the buffer word by word, crossing the half-full mark on the way. It then holds the write request on while the buffer is full until the counter has pinned at its limit. Finally it drains every entry, which confirms that none of the rejected words got into the data stream.

// File: rtl/acq_fifo_pkg.sv
package acq_fifo_pkg;

   typedef struct packed {
      logic wr;
      logic rd;
   } acq_gnt_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/acq_fifo_arb.sv
module acq_fifo_arb
   import acq_fifo_pkg::*;
#(
   parameter bit SIMUL_FROM_HALF = 1'b1
) (
   input  logic     wr_req,
   input  logic     rd_req,
   input  logic     is_empty,
   input  logic     is_half,
   input  logic     is_full,
   output acq_gnt_t gnt
);

   generate
      if (SIMUL_FROM_HALF) begin : g_half_gate
         // Below the half mark a pending write takes the cycle.
         always_comb begin
            gnt.wr = wr_req & ~is_full;
            gnt.rd = rd_req & ~is_empty & (is_half | ~gnt.wr);
         end
      end else begin : g_free_run
         always_comb begin
            gnt.wr = wr_req & ~is_full;
            gnt.rd = rd_req & ~is_empty;
         end
      end
   endgenerate

endmodule

// File: rtl/acq_fifo_ctrl.sv
module acq_fifo_ctrl #(
   parameter int unsigned DEPTH = 4096,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [CW-1:0] count,
   output logic          is_empty,
   output logic          is_half,
   output logic          is_full
);

   localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waddr <= '0;
         raddr <= '0;
         count <= '0;
      end else begin
         if (wr_en) waddr <= waddr + 1'b1;
         if (rd_en) raddr <= raddr + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_comb begin
      is_empty = (count == '0);
      is_half  = (count >= HALF_LVL);
      is_full  = (count == FULL_LVL);
   end

   // R4
   occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_LVL);

   // R5
   full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_full |-> is_half);

   // R4
   full_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_full |=> count <= FULL_LVL && !$rose(is_empty));

endmodule

// File: rtl/acq_fifo_store.sv
module acq_fifo_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4096,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[waddr] <= wdata;
      if (rd_en) rd_data <= mem[raddr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_en;
   end

endmodule

// File: rtl/acq_fifo_drop.sv
module acq_fifo_drop #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drop_evt,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (drop_evt && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   // R9
   drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

   // R9
   drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_evt && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

   // R9
   drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_evt |=> $stable(cnt));

endmodule

// File: rtl/acq_fifo.sv
module acq_fifo
   import acq_fifo_pkg::*;
#(
   parameter int unsigned DATA_W          = 16,
   parameter int unsigned DEPTH           = 4096,
   parameter int unsigned DROP_W          = 16,
   parameter bit          SIMUL_FROM_HALF = 1'b1,
   localparam int unsigned AW             = $clog2(DEPTH),
   localparam int unsigned CW             = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              empty,
   output logic              half_full,
   output logic              full,
   output logic [DROP_W-1:0] drop_count
);

   generate
      if (!is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
         $error("acq_fifo: DEPTH must be a power of two of at least 4");
      end
      if (DATA_W < 1 || DROP_W < 1) begin : g_bad_width
         $error("acq_fifo: DATA_W and DROP_W must be positive");
      end
   endgenerate

   acq_gnt_t      gnt;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic [CW-1:0] count;

   acq_fifo_arb #(
      .SIMUL_FROM_HALF (SIMUL_FROM_HALF)
   ) u_arb (
      .wr_req   (wr_req),
      .rd_req   (rd_req),
      .is_empty (empty),
      .is_half  (half_full),
      .is_full  (full),
      .gnt      (gnt)
   );

   acq_fifo_ctrl #(
      .DEPTH (DEPTH)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (gnt.wr),
      .rd_en    (gnt.rd),
      .waddr    (waddr),
      .raddr    (raddr),
      .count    (count),
      .is_empty (empty),
      .is_half  (half_full),
      .is_full  (full)
   );

   acq_fifo_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (gnt.wr),
      .waddr    (waddr),
      .wdata    (wr_data),
      .rd_en    (gnt.rd),
      .raddr    (raddr),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   acq_fifo_drop #(
      .CNT_W (DROP_W)
   ) u_drop (
      .clk      (clk),
      .rst_n    (rst_n),
      .drop_evt (wr_req & full),
      .cnt      (drop_count)
   );

   // R3
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr_req) |=> (!rd_valid && empty));

   // R10
   empty_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && wr_req && rd_req) |=> (!rd_valid && !empty));

   // R8
   full_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_req && rd_req) |=> (rd_valid && !full));

   // R4
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_req && !rd_req) |=> (full && !rd_valid));

   generate
      if (SIMUL_FROM_HALF) begin : g_policy_chk
         // R6
         low_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!half_full && !empty && wr_req && rd_req) |=>
               (!rd_valid && count == $past(count) + 1'b1));

         // R7
         mid_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (half_full && !full && wr_req && rd_req) |=>
               (rd_valid && $stable(count)));
      end
   endgenerate

endmodule

// File: tb/test_acq_fifo.sv
module test_acq_fifo;

   localparam int PERIOD  = 10;
   localparam int DEPTH   = 4096;
   localparam int HALF    = DEPTH / 2;
   localparam int DROPMAX = 65535;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_req = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_req = 1'b0;
   logic [15:0] rd_data;
   logic        rd_valid;
   logic        empty;
   logic        half_full;
   logic        full;
   logic [15:0] drop_count;

   int n_vec  = 0;
   int n_miss = 0;

   logic [15:0] q [DEPTH];
   int head = 0;
   int tail = 0;
   int mcnt = 0;
   int mdrop = 0;
   int seq = 0;

   always #(PERIOD/2) clk = ~clk;

   acq_fifo i_acq_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req     (wr_req),
      .wr_data    (wr_data),
      .rd_req     (rd_req),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .empty      (empty),
      .half_full  (half_full),
      .full       (full),
      .drop_count (drop_count)
   );

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_miss++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic check_flags(input string tag);
      chk(tag, "empty", int'(empty), int'(mcnt == 0));
      chk(tag, "half_full", int'(half_full), int'(mcnt >= HALF));
      chk(tag, "full", int'(full), int'(mcnt == DEPTH));
      chk(tag, "drop_count", int'(drop_count), mdrop);
   endtask

   // One clock: drive at the falling edge, let the rising edge act, compare at the next falling edge.
   task automatic step(input bit w, input logic [15:0] d, input bit r, input string tag);
      bit wa;
      bit ra;
      logic [15:0] exp_d;
      exp_d = '0;
      wa = w && (mcnt < DEPTH);
      ra = r && (mcnt > 0) && ((mcnt >= HALF) || !wa);
      wr_req  = w;
      wr_data = d;
      rd_req  = r;
      if (ra) begin
         exp_d = q[head];
         head  = (head + 1) % DEPTH;
      end
      if (wa) begin
         q[tail] = d;
         tail    = (tail + 1) % DEPTH;
      end
      if (w && !wa && mdrop != DROPMAX) mdrop++;
      mcnt = mcnt + int'(wa) - int'(ra);
      @(posedge clk);
      #(PERIOD/2);
      chk(tag, "rd_valid", int'(rd_valid), int'(ra));
      if (ra) chk(tag, "rd_data", int'(rd_data), int'(exp_d));
      check_flags(tag);
   endtask

   function automatic logic [15:0] next_word();
      seq++;
      return 16'(seq * 37 + 5);
   endfunction

   task automatic t_reset();
      chk("R1", "rd_valid", int'(rd_valid), 0);
      chk("R1", "empty", int'(empty), 1);
      chk("R1", "half_full", int'(half_full), 0);
      chk("R1", "full", int'(full), 0);
      chk("R1", "drop_count", int'(drop_count), 0);
   endtask

   task automatic t_empty_access();
      step(1'b0, '0, 1'b1, "R3");
      step(1'b0, '0, 1'b1, "R3");
      step(1'b1, 16'hA5A5, 1'b1, "R10");
      chk("R10", "occupancy one", int'(empty), 0);
      step(1'b0, '0, 1'b1, "R2");
      step(1'b0, '0, 1'b0, "R3");
   endtask

   task automatic t_low_both();
      for (int i = 0; i < 3; i++) step(1'b1, next_word(), 1'b0, "R2");
      for (int i = 0; i < 3; i++) step(1'b1, next_word(), 1'b1, "R6");
      for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1, "R2");
      step(1'b0, '0, 1'b1, "R3");
   endtask

   task automatic t_half_mark();
      for (int i = 0; i < HALF - 1; i++) step(1'b1, next_word(), 1'b0, "R5");
      chk("R5", "half below mark", int'(half_full), 0);
      step(1'b1, next_word(), 1'b0, "R5");
      chk("R5", "half at mark", int'(half_full), 1);
      for (int i = 0; i < 5; i++) step(1'b1, next_word(), 1'b1, "R7");
      step(1'b0, '0, 1'b1, "R5");
      chk("R5", "half after drain", int'(half_full), 0);
      step(1'b1, next_word(), 1'b1, "R6");
   endtask

   task automatic t_fill_full();
      while (mcnt < DEPTH - 1) step(1'b1, next_word(), 1'b0, "R4");
      chk("R4", "full one short", int'(full), 0);
      step(1'b1, next_word(), 1'b0, "R4");
      chk("R4", "full at depth", int'(full), 1);
      for (int i = 0; i < 3; i++) step(1'b1, 16'hDEAD, 1'b0, "R4");
      step(1'b1, 16'hBEEF, 1'b1, "R8");
      chk("R8", "full cleared", int'(full), 0);
      step(1'b1, next_word(), 1'b1, "R7");
      step(1'b1, next_word(), 1'b0, "R4");
   endtask

   task automatic t_drop_saturate();
      while (mdrop < DROPMAX) step(1'b1, 16'hD000, 1'b0, "R9");
      for (int i = 0; i < 4; i++) step(1'b1, 16'hD001, 1'b0, "R9");
      chk("R9", "saturated", int'(drop_count), DROPMAX);
   endtask

   task automatic t_drain();
      while (mcnt > 0) step(1'b0, '0, 1'b1, "R2");
      step(1'b0, '0, 1'b1, "R3");
      chk("R4", "drained empty", int'(empty), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_vec++;
      n_miss++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #(PERIOD/2);
      t_reset();
      rst_n = 1'b1;
      @(posedge clk);
      #(PERIOD/2);
      t_reset();
      t_empty_access();
      t_low_both();
      t_half_mark();
      t_fill_full();
      t_drop_saturate();
      t_drain();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

endmodule